// File: doc/BRIEF.md
# Completion Signal Timeout Timer

This block is a programmable watchdog for the host side of a memory-card controller. It measures how long the host waits for the device to raise its completion signal. A small configuration register holds a 4-bit cycle count and a 3-bit multiplier code. The timeout limit, in master-clock cycles, is the cycle count times the multiplier that the code selects.

The timer arms in one of two ways. For a data command it arms when the data transfer ends, and that end includes any busy phase. For a command that moves no data it arms when the response ends. Once armed, it counts master-clock cycles until the completion signal arrives. If the count passes the limit first, a sticky error flag rises and stays set until a clear strobe.

The protocol engine produces the arming pulses and the completion input, and it reads and clears the error flag. The configuration register accepts writes only while the write-protect input is low.

Top module: `cst_timer`

## Requirements
- R1: With cycle count C and multiplier M, the limit is L = C*M. `tmo_err` rises after the (L+1)-th rising clock edge that follows the arming edge, provided completion has not arrived.
- R2: The multiplier code selects these multipliers: 0→1, 1→16, 2→128, 3→256, 4→1024, 5→4096, 6→65536, 7→1048576.
- R3: A one-cycle pulse on `xfer_done` arms the timer. This input marks the end of a data transfer, busy phase included.
- R4: `rsp_done` arms the timer only while `nodata_cmd` is high. `rsp_done` with `nodata_cmd` low has no effect.
- R5: `comp_sig` high while armed stops and clears the count without setting the error. This also holds in the cycle in which the limit would otherwise be passed.
- R6: `tmo_err` stays set until `clr_err` is high. When a timeout and `clr_err` fall on the same edge, the timeout wins.
- R7: An arming pulse while already armed restarts the count from zero. Arming takes priority over both completion and timeout.
- R8: With a cycle count of 0, the error rises on the first clock edge after the arming edge.
- R9: A write while `wp_en` is high is ignored, and the register contents stay as they were.
- R10: Register layout: bits 3:0 hold the cycle count and bits 6:4 hold the multiplier code. Bit 7 is ignored on write and reads as 0. `cfg_rdata` shows a write from the edge that follows it.
- R11: Synchronous reset clears the register fields, the count, the armed state and the error flag.
- R12: `waiting` is high from the edge after arming until the edge at which completion or the timeout ends the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| wp_en | input | 1 | Write protect; blocks writes while high |
| cfg_rdata | output | 8 | Configuration register readback |
| xfer_done | input | 1 | End of data transfer including busy phase |
| rsp_done | input | 1 | End of command response |
| nodata_cmd | input | 1 | Current command moves no data |
| comp_sig | input | 1 | Completion signal from the device |
| clr_err | input | 1 | Clear strobe for the error flag |
| waiting | output | 1 | Timer is armed and counting |
| tmo_err | output | 1 | Sticky completion-timeout error |

## Verification
The bench measures the exact latency from arming to the error for every multiplier code except the largest. An off-by-one compare, or a wrong entry in the code-to-multiplier decode, would give a different cycle count. Completion is raised in the very cycle in which the limit would be passed, so a design that checks the timeout before the completion would flag a false error. The bench also re-arms in the middle of a count, collides a clear strobe with a timeout, pulses a response end for a data command, and writes while write-protected. A design that got any of these wrong would show an early error, a lost error, a spurious arm or a corrupted readback.

// File: rtl/cst_pkg.sv
package cst_pkg;

    localparam int CYC_W     = 4;
    localparam int CODE_W    = 3;
    localparam int REG_W     = 8;
    localparam int MAX_SHIFT = 20;
    localparam int CNT_W     = CYC_W + MAX_SHIFT;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CYC_W-1:0]  cyc;
    } cst_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } cst_state_t;

    // every multiplier is a power of two, so the product is a shift
    function automatic logic [4:0] code_shift(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    code_shift = 5'd0;
            3'd1:    code_shift = 5'd4;
            3'd2:    code_shift = 5'd7;
            3'd3:    code_shift = 5'd8;
            3'd4:    code_shift = 5'd10;
            3'd5:    code_shift = 5'd12;
            3'd6:    code_shift = 5'd16;
            default: code_shift = 5'd20;
        endcase
    endfunction

endpackage

// File: rtl/cst_cfg_reg.sv
module cst_cfg_reg
    import cst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             wp,
    input  logic [REG_W-1:0] wdata,
    output cst_cfg_t         cfg,
    output logic [REG_W-1:0] rdata
);
    localparam int FLD_W = CYC_W + CODE_W;

    cst_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we && !wp) begin
            cfg_q <= cst_cfg_t'(wdata[FLD_W-1:0]);
        end
    end

    assign cfg = cfg_q;

    generate
        if (REG_W > FLD_W) begin : g_pad
            assign rdata = {{(REG_W-FLD_W){1'b0}}, cfg_q};
        end else begin : g_nopad
            assign rdata = cfg_q;
        end
    endgenerate
endmodule

// File: rtl/cst_limit.sv
module cst_limit
    import cst_pkg::*;
(
    input  cst_cfg_t         cfg,
    output logic [CNT_W-1:0] limit
);
    logic [4:0] sh;

    always_comb begin
        sh    = code_shift(cfg.code);
        limit = CNT_W'(cfg.cyc) << sh;
    end
endmodule

// File: rtl/cst_counter.sv
module cst_counter
    import cst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             comp,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             busy,
    output logic             err
);
    cst_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             hit;

    always_comb begin
        hit = (st_q == ST_WAIT) && !arm && !comp && (cnt_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else if (arm) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
        end else if (st_q == ST_WAIT) begin
            if (comp || hit) begin
                st_q  <= ST_IDLE;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (hit) begin
            err_q <= 1'b1;
        end else if (clr) begin
            err_q <= 1'b0;
        end
    end

    assign busy = (st_q == ST_WAIT);
    assign err  = err_q;
endmodule

// File: rtl/cst_timer.sv
module cst_timer
    import cst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             wp_en,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             xfer_done,
    input  logic             rsp_done,
    input  logic             nodata_cmd,
    input  logic             comp_sig,
    input  logic             clr_err,
    output logic             waiting,
    output logic             tmo_err
);
    cst_cfg_t         cfg;
    logic [CNT_W-1:0] limit;
    logic             arm;

    assign arm = xfer_done || (rsp_done && nodata_cmd);

    cst_cfg_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wp    (wp_en),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    cst_limit u_limit (
        .cfg   (cfg),
        .limit (limit)
    );

    cst_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm),
        .comp  (comp_sig),
        .clr   (clr_err),
        .limit (limit),
        .busy  (waiting),
        .err   (tmo_err)
    );
endmodule

// File: rtl/cst_timer_chk.sv
module cst_timer_chk
    import cst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             wp_en,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             xfer_done,
    input logic             rsp_done,
    input logic             nodata_cmd,
    input logic             comp_sig,
    input logic             clr_err,
    input logic             waiting,
    input logic             tmo_err
);
    logic arm_c;
    assign arm_c = xfer_done || (rsp_done && nodata_cmd);

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!tmo_err && !waiting && cfg_rdata == '0));

    a_r9_wp_blocks: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && wp_en) |=> $stable(cfg_rdata));

    a_r10_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[REG_W-1] == 1'b0);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (tmo_err && !clr_err) |=> tmo_err);

    a_r5_comp_no_err: assert property (@(posedge clk) disable iff (rst)
        (waiting && comp_sig && !arm_c && !tmo_err) |=> (!tmo_err && !waiting));

    a_r12_arm_waits: assert property (@(posedge clk) disable iff (rst)
        arm_c |=> waiting);

    a_r4_rsp_no_arm: assert property (@(posedge clk) disable iff (rst)
        (!waiting && rsp_done && !nodata_cmd && !xfer_done) |=> !waiting);

    a_r8_zero_fires: assert property (@(posedge clk) disable iff (rst)
        (waiting && cfg_rdata[CYC_W-1:0] == '0 && !comp_sig && !arm_c) |=> tmo_err);
endmodule

bind cst_timer cst_timer_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .wp_en      (wp_en),
    .cfg_rdata  (cfg_rdata),
    .xfer_done  (xfer_done),
    .rsp_done   (rsp_done),
    .nodata_cmd (nodata_cmd),
    .comp_sig   (comp_sig),
    .clr_err    (clr_err),
    .waiting    (waiting),
    .tmo_err    (tmo_err)
);

// File: tb/test_cst_timer.sv
`timescale 1ns/1ps
module test_cst_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       wp_en = 1'b0;
    logic [7:0] cfg_rdata;
    logic       xfer_done = 1'b0;
    logic       rsp_done = 1'b0;
    logic       nodata_cmd = 1'b0;
    logic       comp_sig = 1'b0;
    logic       clr_err = 1'b0;
    logic       waiting;
    logic       tmo_err;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int since_arm = 0;
    bit err_prev = 0;
    int exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    cst_timer i_cst_timer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wp_en(wp_en), .cfg_rdata(cfg_rdata), .xfer_done(xfer_done),
        .rsp_done(rsp_done), .nodata_cmd(nodata_cmd), .comp_sig(comp_sig),
        .clr_err(clr_err), .waiting(waiting), .tmo_err(tmo_err)
    );

    // edges since the last arming edge
    always @(posedge clk) begin
        if (xfer_done || (rsp_done && nodata_cmd)) since_arm <= 0;
        else since_arm <= since_arm + 1;
    end

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: each error rise is compared with the expected latency
    always @(negedge clk) begin
        if (!rst && tmo_err && !err_prev) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected error rise", since_arm, -1);
            end else begin
                check(tag_q.pop_front(), since_arm, exp_q.pop_front());
            end
        end
        err_prev = tmo_err;
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic arm_xfer();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 0;
    endtask

    // driver: push expected latency, arm, wait for monitor to consume it
    task automatic expect_timeout(input string tag, input int lat, input bit nodata);
        exp_q.push_back(lat);
        tag_q.push_back(tag);
        if (nodata) begin
            @(negedge clk); rsp_done = 1'b1; nodata_cmd = 1'b1;
            @(negedge clk); rsp_done = 1'b0; nodata_cmd = 1'b0;
        end else begin
            arm_xfer();
        end
        for (int i = 0; i < lat + 4 && exp_q.size() != 0; i++) @(negedge clk);
        if (exp_q.size() != 0) begin
            check({tag, " error never rose"}, 0, 1);
            exp_q.delete();
            tag_q.delete();
        end
        clear_err();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset rdata", cfg_rdata, 0);
        check("R11 reset err", tmo_err, 0);
        check("R11 reset waiting", waiting, 0);
        rst = 1'b0;

        // R10 layout and unused bit
        wr(8'hB5);
        check("R10 readback drops bit7", cfg_rdata, 8'h35);
        // R9 write protect
        wp_en = 1'b1;
        wr(8'h12);
        check("R9 protected write ignored", cfg_rdata, 8'h35);
        wp_en = 1'b0;

        // R1 limit 3 cycles
        wr(8'h03);
        expect_timeout("R1 C=3 M=1", 4, 0);
        check("R6 cleared by strobe", tmo_err, 0);

        // R2 multiplier codes 0..6 with C=1
        for (int c = 0; c < 7; c++) begin
            int m;
            case (c)
                0: m = 1; 1: m = 16; 2: m = 128; 3: m = 256;
                4: m = 1024; 5: m = 4096; default: m = 65536;
            endcase
            wr(8'((c << 4) | 1));
            expect_timeout($sformatf("R2 code %0d", c), m + 1, 0);
        end

        // R2 code 7: C=1 gives 1048576, nothing within 3000 cycles
        wr(8'h71);
        arm_xfer();
        repeat (3000) @(negedge clk);
        check("R2 code7 no early error", tmo_err, 0);
        check("R12 still waiting", waiting, 1);
        @(negedge clk); comp_sig = 1'b1;
        @(negedge clk); comp_sig = 1'b0;
        check("R12 waiting drops on completion", waiting, 0);

        // R1 with C=2 M=16 and R3 data arming
        wr(8'h12);
        expect_timeout("R3 data arm C=2 M=16", 33, 0);

        // R4 no-data response arming
        wr(8'h05);
        expect_timeout("R4 nodata arm", 6, 1);
        @(negedge clk); rsp_done = 1'b1; nodata_cmd = 1'b0;
        @(negedge clk); rsp_done = 1'b0;
        check("R4 rsp without nodata not waiting", waiting, 0);
        repeat (10) @(negedge clk);
        check("R4 rsp without nodata no error", tmo_err, 0);

        // R5 completion at the exact boundary edge
        wr(8'h03);
        arm_xfer();
        repeat (3) @(negedge clk);
        comp_sig = 1'b1;
        @(negedge clk); comp_sig = 1'b0;
        check("R5 boundary completion waiting", waiting, 0);
        repeat (8) @(negedge clk);
        check("R5 boundary completion no error", tmo_err, 0);

        // R7 re-arm restarts the count
        arm_xfer();
        repeat (2) @(negedge clk);
        expect_timeout("R7 restart latency", 4, 0);

        // R8 zero count
        wr(8'h70);
        expect_timeout("R8 zero count", 1, 0);

        // R6 set wins over clear on the same edge, then stays sticky
        exp_q.push_back(1);
        tag_q.push_back("R6 collide latency");
        arm_xfer();
        clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        check("R6 set beats clear", tmo_err, 1);
        repeat (20) @(negedge clk);
        check("R6 sticky", tmo_err, 1);
        clear_err();
        check("R6 clear", tmo_err, 0);
        check("R1 queue drained", exp_q.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule